// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that works through a chain of descriptors held in system memory. Software first loads the address of the first descriptor into the channel's pointer register. It then sets the enable bit. The channel reads the five-word descriptor through its memory master port and moves the buffer that the descriptor describes. When the buffer is finished, it records completion in memory and moves on to the next descriptor. Software watches each buffer by reading the done flag that the channel writes into the descriptor's control word in memory.

Each descriptor holds five words, in this order:

| Offset | Content |
|---|---|
| 0 | Source address |
| 4 | Destination address |
| 8 | Next-descriptor pointer |
| 12 | Control word A |
| 16 | Control word B |

Fields of control word A:

- bits [SZW-1:0]: buffer size, counted in 32-bit items.
- bit 31: done flag.

Bits of control word B select how the addresses advance:

- bit 0 set: the source address advances by 4 after each item.
- bit 1 set: the destination address advances by 4 after each item.
- Bit clear: the address stays fixed, as for a peripheral FIFO.

A source and a destination peripheral pace the data movement with request/acknowledge handshakes. A chunk request moves up to CHUNK items in one transaction. A single request moves one item.

Top module: `llchain_dma`

## Requirements
- R1: After reset, `chan_en`, `buf_irq`, `chain_irq`, `mem_req_valid`, `src_ack` and `dst_ack` are all low.
- R2: When `sw_en_set` is applied to an idle channel, the channel first issues five reads, at pointer+0, +4, +8, +12 and +16 in ascending order. It issues no data access before these five reads.
- R3: While the channel is running, `sw_ptr_wr` and `sw_en_set` are ignored. The chain in progress follows only the descriptors it fetches.
- R4: A transaction starts only when `src_req` and `dst_req` are both high. If `src_chunk` is 1, the transaction moves min(CHUNK, remaining) items; otherwise it moves one item. Each item is a read of the source address followed by a write of the read data to the destination address. After the last write of the transaction, `src_ack` and `dst_ack` pulse high together for one cycle.
- R5: When control word B bit 0 is set, the source address advances by 4 after each item; when it is clear, the source address stays fixed. Bit 1 controls the destination address in the same way.
- R6: When a buffer ends, the channel makes exactly one write to the descriptor, at descriptor+12. The written value has bit 31 = 1, bits [15:0] = 0 (the remaining size), and bits [30:16] unchanged from the fetched control word A. The other four descriptor words are never written.
- R7: A descriptor with size 0 moves no data and produces no acknowledge. The channel goes directly to the write-back.
- R8: After a write-back, the channel fetches the next descriptor from the next pointer without waiting for `buf_irq` to be cleared. If the next pointer is 0, `chan_en` falls instead, and `chain_irq` is high for exactly that one cycle.
- R9: `buf_irq` is set by each accepted write-back and stays set until `sw_irq_clr` is applied. If the set and the clear fall in the same cycle, the set wins.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request keeps its valid, write flag, address and write data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_ptr_wr | input | 1 | Load the descriptor pointer (accepted only while idle) |
| sw_ptr_val | input | 32 | Value for the descriptor pointer |
| sw_en_set | input | 1 | Writing 1 enables the channel |
| sw_irq_clr | input | 1 | Writing 1 clears `buf_irq` |
| chan_en | output | 1 | Channel enable bit (high while the chain runs) |
| buf_irq | output | 1 | Sticky buffer-complete flag |
| chain_irq | output | 1 | One-cycle pulse when the chain ends |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| src_req | input | 1 | Source peripheral requests a transaction |
| src_chunk | input | 1 | 1 = chunk transaction, 0 = single item |
| src_ack | output | 1 | Transaction complete, to the source |
| dst_req | input | 1 | Destination peripheral is ready for a transaction |
| dst_ack | output | 1 | Transaction complete, to the destination |

## Verification
The write-back that sets `buf_irq` and a software clear can land in the same cycle. The bench provokes this by holding `sw_irq_clr` high for an entire chain. It then counts the cycles in which `buf_irq` is high and expects exactly one per descriptor, which shows that each set won its clash. The write-back and the immediate fetch of the next descriptor are judged from the bench memory afterwards: each control word A must carry done=1 and size 0, and all other descriptor words must be untouched. Across a sweep of buffer sizes, transaction kinds, address modes and memory stalls, the bench also predicts the destination contents and the acknowledge count arithmetically.

// File: rtl/llchain_dma.sv
module llchain_dma #(
  parameter int SZW   = 16,
  parameter int CHUNK = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_ptr_wr,
  input  logic [31:0] sw_ptr_val,
  input  logic        sw_en_set,
  input  logic        sw_irq_clr,
  output logic        chan_en,
  output logic        buf_irq,
  output logic        chain_irq,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  input  logic        src_req,
  input  logic        src_chunk,
  output logic        src_ack,
  input  logic        dst_req,
  output logic        dst_ack
);

  localparam logic [SZW-1:0] CHUNK_SZ = SZW'(CHUNK);
  localparam logic [SZW-1:0] ONE      = SZW'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FRSP, S_WAIT, S_RD, S_RRSP, S_WR, S_ACK, S_WB
  } st_t;

  st_t            st;
  logic [31:0]    cur, saddr, daddr, nxt, ctla, ctlb, dbuf;
  logic [SZW-1:0] remain, txn;
  logic [2:0]     idx;
  logic           acc;

  assign acc           = mem_req_valid && mem_req_ready;
  assign chan_en       = (st != S_IDLE);
  assign src_ack       = (st == S_ACK);
  assign dst_ack       = (st == S_ACK);
  assign mem_req_valid = (st == S_FREQ) || (st == S_RD) || (st == S_WR) || (st == S_WB);
  assign mem_req_write = (st == S_WR) || (st == S_WB);
  assign mem_req_wdata = (st == S_WB) ? {1'b1, ctla[30:SZW], remain} : dbuf;

  always_comb begin
    case (st)
      S_FREQ:  mem_req_addr = cur + {27'd0, idx, 2'b00};
      S_RD:    mem_req_addr = saddr;
      S_WR:    mem_req_addr = daddr;
      S_WB:    mem_req_addr = cur + 32'd12;
      default: mem_req_addr = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0; saddr <= '0; daddr <= '0; nxt <= '0;
      ctla <= '0; ctlb <= '0; dbuf <= '0;
      remain <= '0; txn <= '0; idx <= '0;
      buf_irq <= 1'b0;
      chain_irq <= 1'b0;
    end else begin
      chain_irq <= 1'b0;
      if (sw_irq_clr) buf_irq <= 1'b0;
      case (st)
        S_IDLE: begin
          if (sw_ptr_wr) nxt <= sw_ptr_val;
          if (sw_en_set) begin
            cur <= sw_ptr_wr ? sw_ptr_val : nxt;
            idx <= 3'd0;
            st  <= S_FREQ;
          end
        end
        S_FREQ: if (acc) st <= S_FRSP;
        S_FRSP: if (mem_rsp_valid) begin
          case (idx)
            3'd0:    saddr <= mem_rsp_rdata;
            3'd1:    daddr <= mem_rsp_rdata;
            3'd2:    nxt   <= mem_rsp_rdata;
            3'd3:    ctla  <= mem_rsp_rdata;
            default: ctlb  <= mem_rsp_rdata;
          endcase
          if (idx == 3'd4) begin
            remain <= ctla[SZW-1:0];
            st     <= S_WAIT;
          end else begin
            idx <= idx + 3'd1;
            st  <= S_FREQ;
          end
        end
        S_WAIT: begin
          if (remain == '0) st <= S_WB;
          else if (src_req && dst_req) begin
            if (!src_chunk)             txn <= ONE;
            else if (remain > CHUNK_SZ) txn <= CHUNK_SZ;
            else                        txn <= remain;
            st <= S_RD;
          end
        end
        S_RD: if (acc) st <= S_RRSP;
        S_RRSP: if (mem_rsp_valid) begin
          dbuf <= mem_rsp_rdata;
          st   <= S_WR;
        end
        S_WR: if (acc) begin
          if (ctlb[0]) saddr <= saddr + 32'd4;
          if (ctlb[1]) daddr <= daddr + 32'd4;
          remain <= remain - ONE;
          txn    <= txn - ONE;
          st     <= (txn == ONE) ? S_ACK : S_RD;
        end
        S_ACK: st <= S_WAIT;
        S_WB: if (acc) begin
          buf_irq <= 1'b1;
          if (nxt == 32'd0) begin
            chain_irq <= 1'b1;
            st        <= S_IDLE;
          end else begin
            cur <= nxt;
            idx <= 3'd0;
            st  <= S_FREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> (!mem_req_valid && !src_ack && !dst_ack)); // R1

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write)
      && $stable(mem_req_addr) && $stable(mem_req_wdata))); // R10

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    src_ack |=> !src_ack); // R4

  AST_CHAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    chain_irq |-> (!chan_en && $past(chan_en))); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_irq && !sw_irq_clr) |=> buf_irq); // R9

  AST_WB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB && acc) |=> buf_irq); // R9

endmodule

// File: tb/tb_llchain_dma.sv
module tb_llchain_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_ptr_wr = 1'b0, sw_en_set = 1'b0, sw_irq_clr = 1'b0;
  logic [31:0] sw_ptr_val = '0;
  logic chan_en, buf_irq, chain_irq;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic src_req = 1'b0, src_chunk = 1'b0, dst_req = 1'b0;
  logic src_ack, dst_ack;

  always #5 clk = ~clk;

  llchain_dma dut (
    .clk(clk), .rst_n(rst_n),
    .sw_ptr_wr(sw_ptr_wr), .sw_ptr_val(sw_ptr_val), .sw_en_set(sw_en_set), .sw_irq_clr(sw_irq_clr),
    .chan_en(chan_en), .buf_irq(buf_irq), .chain_irq(chain_irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .src_req(src_req), .src_chunk(src_chunk), .src_ack(src_ack),
    .dst_req(dst_req), .dst_ack(dst_ack));

  int total = 0, bad = 0;
  logic [31:0] mem [0:255];
  bit pend = 0;
  logic [31:0] paddr = '0;
  int cyc = 0;
  bit stall = 0, per_on = 0;
  int log_n = 0;
  logic [31:0] log_a [0:7];
  bit log_w [0:7];
  int stray = 0, n_ack = 0, ack_mis = 0, n_chain = 0, chain_bad = 0, n_irqhi = 0;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_rdata = mem[paddr[9:2]];
      pend = 0;
    end
    mem_req_ready = stall ? ((cyc % 3) != 1) : 1'b1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (log_n < 8) begin
        log_a[log_n] = mem_req_addr;
        log_w[log_n] = mem_req_write;
        log_n++;
      end
      if (mem_req_write) begin
        if (!((mem_req_addr >= 32'h180 && mem_req_addr < 32'h1A0) ||
              (mem_req_addr >= 32'h280 && mem_req_addr < 32'h2A0) ||
              mem_req_addr == 32'h4C || mem_req_addr == 32'h6C)) stray++;
        mem[mem_req_addr[9:2]] = mem_req_wdata;
      end else begin
        pend = 1;
        paddr = mem_req_addr;
      end
    end
    cyc++;
    if (src_ack) begin
      n_ack++;
      if (!dst_ack) ack_mis++;
      src_req = 1'b0;
      dst_req = 1'b0;
    end else if (per_on) begin
      src_req = 1'b1;
      dst_req = 1'b1;
    end
    if (chain_irq) begin
      n_chain++;
      if (chan_en) chain_bad++;
    end
    if (buf_irq) n_irqhi++;
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int b, int i, int k);
    return 32'hA000_0000 + 32'(b * 4096 + i * 17 + k);
  endfunction

  function automatic int nacks(int n, int ck);
    return ck ? (n + 3) / 4 : n;
  endfunction

  task automatic check_buf(int b, int n, int im, int k, int dbase, string req);
    logic [31:0] exp [0:7];
    int mis = 0;
    for (int s = 0; s < 8; s++) exp[s] = '0;
    for (int i = 0; i < n; i++) exp[im[1] ? i : 0] = pat(b, im[0] ? i : 0, k);
    for (int s = 0; s < 8; s++) if (mem[dbase + s] !== exp[s]) mis++;
    chk(mis == 0, req, $sformatf("dst buffer %0d n=%0d mode=%0d", b, n, im), 32'(mis), 32'd0);
  endtask

  task automatic run(int n0, int ck, int im, bit stl, bit hold);
    int n1 = (n0 + 3) % 7;
    int t;
    for (int a = 0; a < 256; a++) mem[a] = '0;
    mem[16] = 32'h100; mem[17] = 32'h180; mem[18] = 32'h60;
    mem[19] = {1'b0, 15'h2A5A, 16'(n0)}; mem[20] = 32'(im);
    mem[24] = 32'h200; mem[25] = 32'h280; mem[26] = 32'h0;
    mem[27] = {1'b0, 15'h1234, 16'(n1)}; mem[28] = 32'(im);
    for (int i = 0; i < 8; i++) begin
      mem[64 + i]  = pat(0, i, n0);
      mem[128 + i] = pat(1, i, n0);
    end
    log_n = 0; stray = 0; n_ack = 0; ack_mis = 0; n_chain = 0; chain_bad = 0;
    stall = stl; src_chunk = ck[0]; per_on = 1;
    @(negedge clk); sw_ptr_wr = 1'b1; sw_ptr_val = 32'h40;
    @(negedge clk); sw_ptr_wr = 1'b0; sw_en_set = 1'b1;
    @(negedge clk); sw_en_set = 1'b0; sw_irq_clr = hold;
    n_irqhi = 0;
    repeat (3) @(negedge clk);
    sw_ptr_wr = 1'b1; sw_ptr_val = 32'h3F0; sw_en_set = 1'b1;   // R3 ignored while running
    @(negedge clk); sw_ptr_wr = 1'b0; sw_en_set = 1'b0;
    t = 0;
    while (chan_en && t < 4000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(t < 4000, "R8", "watchdog: chain did not finish", 32'(t), 32'd4000);
    per_on = 0;
    chk(log_n >= 5 && log_a[0] == 32'h40 && log_a[1] == 32'h44 && log_a[2] == 32'h48 &&
        log_a[3] == 32'h4C && log_a[4] == 32'h50 && !log_w[0] && !log_w[1] && !log_w[2] &&
        !log_w[3] && !log_w[4], "R2", "first five accesses", log_a[4], 32'h50);
    chk(mem[19] == {1'b1, 15'h2A5A, 16'h0}, "R6", "ctlA write-back desc0", mem[19], {1'b1, 15'h2A5A, 16'h0});
    chk(mem[27] == {1'b1, 15'h1234, 16'h0}, "R6", "ctlA write-back desc1", mem[27], {1'b1, 15'h1234, 16'h0});
    chk(mem[16] == 32'h100 && mem[17] == 32'h180 && mem[18] == 32'h60 && mem[20] == 32'(im) &&
        mem[24] == 32'h200 && mem[25] == 32'h280 && mem[26] == 32'h0 && mem[28] == 32'(im) && stray == 0,
        "R6", "descriptor words untouched / no stray write", 32'(stray), 32'd0);
    check_buf(0, n0, im, n0, 96, (n0 == 0) ? "R7" : "R5");
    check_buf(1, n1, im, n0, 160, "R3/R4");
    chk(n_ack == nacks(n0, ck) + nacks(n1, ck) && ack_mis == 0, "R4", "ack count",
        32'(n_ack), 32'(nacks(n0, ck) + nacks(n1, ck)));
    chk(n_chain == 1 && chain_bad == 0 && !chan_en, "R8", "chain end pulse", 32'(n_chain), 32'd1);
    if (hold) begin
      chk(n_irqhi == 2, "R9", "set beats clear, cycles high", 32'(n_irqhi), 32'd2);
      sw_irq_clr = 1'b0;
    end else begin
      chk(buf_irq == 1'b1, "R9", "flag still set without clear", 32'(buf_irq), 32'd1);
      sw_irq_clr = 1'b1; @(negedge clk); sw_irq_clr = 1'b0; @(negedge clk);
      chk(buf_irq == 1'b0, "R9", "flag cleared", 32'(buf_irq), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!chan_en && !buf_irq && !chain_irq && !mem_req_valid && !src_ack && !dst_ack,
        "R1", "reset state", {26'd0, chan_en, buf_irq, chain_irq, mem_req_valid, src_ack, dst_ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n0 = 0; n0 < 7; n0++)
      for (int ck = 0; ck < 2; ck++)
        for (int im = 0; im < 4; im++)
          run(n0, ck, im, n0[0], (im == 3 && ck == 1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule